// File: doc/BRIEF.md
# Predicated Nested Element Loop Sequencer

This block produces the element issue order for one vectorised scalar operation. After a start pulse it walks an outer element index upward from a start position to the effective vector length minus one. For every element it walks an inner sub-element index from zero to the group size minus one. The caller's program counter stays held for the whole run. One predicate bit, taken from a captured mask, governs each outer iteration. That bit covers the whole group of sub-elements belonging to the element.

The mask comes from a predicate register value. It can be complemented with an invert flag, and the stored source value is never changed. A select that names register 0 reads as all zeros before inversion. A masked-off element is either skipped or issued as a zero-write, depending on the zeroing flag. In fail-first mode, a fault or a zero result reported on an active element stops the run, and the vector length becomes the index of that element. The current offsets are visible at all times, so a trap handler can save them, and a new start can resume from a saved position.

Issue toward the datapath is a valid/ready stream. When valid is high and ready is low, the element index, the sub-element index and the zero-write flag hold steady, and nothing advances. A transfer happens only in a cycle where valid and ready are both high. The datapath reports the result status for the offered sub-element in that same cycle.

Top module: `elem_loop_seq`

## Requirements
- R1: The effective vector length is the requested length clamped to the range 1..MAXVL: a request of 0 becomes 1, and a request above MAXVL becomes MAXVL. A run that is not cut short reports this value on `vl_o` when `done_o` is high.
- R2: Transfers happen in strictly ascending order: element by element, and within each element sub-element 0 up to SUBVL-1. The `subvl_i` code 0,1,2,3 means a group size of 1,2,3,4.
- R3: Bit e of the mask decides for all sub-elements of element e together.
- R4: When `inv_i` is set, the mask is the complement of `pred_i`.
- R5: When `pred_x0_i` is set, `pred_i` is ignored and the source reads as zero before inversion, so inversion gives an all-ones mask.
- R6: With `zero_i` set, every sub-element of a masked-off element is offered with `zero_wr_o`=1. With `zero_i` clear, a masked-off element is never offered.
- R7: A start with `pred_x0_i`, `inv_i` and `zero_i` all set raises `illegal_o` for one cycle after the start edge. It offers nothing and raises no `done_o`.
- R8: While `issue_valid_o` is high and `issue_ready_i` is low, the offsets and `zero_wr_o` stay stable and valid stays high.
- R9: With `ffirst_i` set, a transfer of an active (unmasked) sub-element of element e with `res_zero_i` or `res_fault_i` high has `commit_o`=0. The run then stops. `done_o` rises with `vl_o`=e, except in the case covered by R10. A zero-write transfer never stops the run.
- R10: A fail-first fault trigger at element 0 raises `fault_o` for one cycle instead of `done_o`, and `vl_o` keeps the effective length.
- R11: With `ffirst_i` clear, `res_zero_i` and `res_fault_i` have no effect. Every transfer commits.
- R12: A start begins at element `resume_elem_i` and sub-element `resume_sub_i`. Later elements start at sub-element 0.
- R13: `done_o` is a one-cycle pulse in the cycle after the final transfer. `busy_o` is then low. While idle, `issue_valid_o` is low and starts are accepted only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| vl_i | input | $clog2(MAXVL+1) | Requested vector length |
| subvl_i | input | 2 | Group size minus one |
| pred_i | input | MAXVL | Predicate register value |
| pred_x0_i | input | 1 | Predicate source is register 0 |
| inv_i | input | 1 | Complement the mask |
| zero_i | input | 1 | Zero masked-off elements |
| ffirst_i | input | 1 | Fail-first mode |
| resume_elem_i | input | $clog2(MAXVL) | Start element index |
| resume_sub_i | input | 2 | Start sub-element index |
| issue_valid_o | output | 1 | Sub-element offered |
| issue_ready_i | input | 1 | Datapath accepts the offer |
| elem_o | output | $clog2(MAXVL) | Current element offset (source and destination) |
| sub_o | output | 2 | Current sub-element offset |
| zero_wr_o | output | 1 | Offer is a zero-write of a masked-off element |
| commit_o | output | 1 | Transfer this cycle is committed |
| res_zero_i | input | 1 | Result of the offered sub-element is zero |
| res_fault_i | input | 1 | The offered sub-element faulted |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed (pulse) |
| fault_o | output | 1 | Fail-first fault at element 0 (pulse) |
| illegal_o | output | 1 | Reserved predicate encoding (pulse) |
| vl_o | output | $clog2(MAXVL+1) | Effective or truncated vector length |

## Verification
Back-pressure and a fail-first trigger can fall in the same cycle. The trigger may arrive on a sub-element that has already been held for several stalled cycles. In that case the stop must happen only at the handshake, with the held offsets, and not earlier. The bench provokes this with a stall pattern while it raises the result status on a chosen element and sub-element. It judges the outcome from the exact list of transfers and the truncated length. A second overlap, between a masked zero-write and a zero result on that same element, is driven to show that zero-writes never stop the run.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} seq_state_e;
  localparam int SUBW = 2;
endpackage

// File: rtl/elem_mask_prep.sv
module elem_mask_prep #(
  parameter int MAXVL = 16
) (
  input  logic [MAXVL-1:0] pred_val,
  input  logic             src_is_x0,
  input  logic             inv,
  input  logic             zeroing,
  output logic [MAXVL-1:0] mask,
  output logic             reserved
);
  logic [MAXVL-1:0] raw;
  always_comb begin
    raw      = src_is_x0 ? '0 : pred_val;
    mask     = raw ^ {MAXVL{inv}};
    reserved = src_is_x0 & inv & zeroing;
  end
endmodule

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int MAXVL = 16,
  localparam int LW = $clog2(MAXVL + 1)
) (
  input  logic [LW-1:0] vl_req,
  output logic [LW-1:0] vl_eff
);
  always_comb begin
    if (vl_req == '0)
      vl_eff = LW'(1);
    else if (vl_req > LW'(MAXVL))
      vl_eff = LW'(MAXVL);
    else
      vl_eff = vl_req;
  end
endmodule

// File: rtl/elem_sub_ctr.sv
module elem_sub_ctr #(
  parameter int EW = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [EW-1:0] load_elem,
  input  logic [SW-1:0] load_sub,
  input  logic          step_elem,
  input  logic          step_sub,
  output logic [EW-1:0] elem,
  output logic [SW-1:0] sub
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem <= '0;
      sub  <= '0;
    end else if (load) begin
      elem <= load_elem;
      sub  <= load_sub;
    end else if (step_elem) begin
      elem <= elem + EW'(1);
      sub  <= '0;
    end else if (step_sub) begin
      sub <= sub + SW'(1);
    end
  end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
  parameter int MAXVL = 16,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int EW = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LW-1:0]    vl_i,
  input  logic [1:0]       subvl_i,
  input  logic [MAXVL-1:0] pred_i,
  input  logic             pred_x0_i,
  input  logic             inv_i,
  input  logic             zero_i,
  input  logic             ffirst_i,
  input  logic [EW-1:0]    resume_elem_i,
  input  logic [1:0]       resume_sub_i,
  output logic             issue_valid_o,
  input  logic             issue_ready_i,
  output logic [EW-1:0]    elem_o,
  output logic [1:0]       sub_o,
  output logic             zero_wr_o,
  output logic             commit_o,
  input  logic             res_zero_i,
  input  logic             res_fault_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             illegal_o,
  output logic [LW-1:0]    vl_o
);
  import elem_loop_pkg::*;

  seq_state_e       state_q;
  logic [MAXVL-1:0] mask_d, mask_q;
  logic [LW-1:0]    vl_eff, vl_q, vl_out_q;
  logic [1:0]       subvl_q;
  logic             zero_q, ff_q, reserved;
  logic             done_q, fault_q, illegal_q;
  logic [EW-1:0]    elem;
  logic [1:0]       sub;

  logic run, cur_bit, active, hs, trig, at_zero_fault;
  logic last_elem, last_sub, grp_end, finish, load;

  elem_mask_prep #(.MAXVL(MAXVL)) u_mask (
    .pred_val (pred_i),
    .src_is_x0(pred_x0_i),
    .inv      (inv_i),
    .zeroing  (zero_i),
    .mask     (mask_d),
    .reserved (reserved)
  );

  vl_clamp #(.MAXVL(MAXVL)) u_clamp (
    .vl_req(vl_i),
    .vl_eff(vl_eff)
  );

  elem_sub_ctr #(.EW(EW), .SW(SUBW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_elem(resume_elem_i),
    .load_sub (resume_sub_i),
    .step_elem(grp_end & ~last_elem),
    .step_sub (commit_o & ~last_sub),
    .elem     (elem),
    .sub      (sub)
  );

  always_comb begin
    run           = (state_q == ST_RUN);
    cur_bit       = mask_q[elem];
    active        = cur_bit | zero_q;
    issue_valid_o = run & active;
    zero_wr_o     = issue_valid_o & ~cur_bit;
    hs            = issue_valid_o & issue_ready_i;
    trig          = hs & ff_q & cur_bit & (res_zero_i | res_fault_i);
    commit_o      = hs & ~trig;
    at_zero_fault = (elem == '0) & res_fault_i;
    last_elem     = (LW'(elem) == vl_q - LW'(1));
    last_sub      = (sub == subvl_q);
    grp_end       = (run & ~active) | (commit_o & last_sub);
    finish        = grp_end & last_elem;
    load          = start_i & ~run & ~reserved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      vl_q      <= LW'(1);
      vl_out_q  <= LW'(1);
      subvl_q   <= '0;
      zero_q    <= 1'b0;
      ff_q      <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= finish | (trig & ~at_zero_fault);
      fault_q   <= trig & at_zero_fault;
      illegal_q <= start_i & ~run & reserved;
      if (load) begin
        state_q  <= ST_RUN;
        mask_q   <= mask_d;
        vl_q     <= vl_eff;
        vl_out_q <= vl_eff;
        subvl_q  <= subvl_i;
        zero_q   <= zero_i;
        ff_q     <= ffirst_i;
      end else if (trig) begin
        state_q <= ST_IDLE;
        if (!at_zero_fault) vl_out_q <= LW'(elem);
      end else if (finish) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign elem_o    = elem;
  assign sub_o     = sub;
  assign busy_o    = run;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign illegal_o = illegal_q;
  assign vl_o      = vl_out_q;
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
  parameter int MAXVL = 16,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int EW = $clog2(MAXVL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          pred_x0_i,
  input logic          inv_i,
  input logic          zero_i,
  input logic          issue_valid_o,
  input logic          issue_ready_i,
  input logic [EW-1:0] elem_o,
  input logic [1:0]    sub_o,
  input logic          zero_wr_o,
  input logic          commit_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          illegal_o,
  input logic [LW-1:0] vl_o
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o && !issue_ready_i |=>
      issue_valid_o && $stable(elem_o) && $stable(sub_o) && $stable(zero_wr_o));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !issue_valid_o);

  p_single_event_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, illegal_o}));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && pred_x0_i && inv_i && zero_i |=> illegal_o && !busy_o);

  p_vl_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> vl_o <= LW'(MAXVL));

  p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> elem_o >= $past(elem_o));

  p_ff_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o && issue_ready_i && !commit_o |=> !busy_o);
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pred_x0_i(pred_x0_i),
  .inv_i(inv_i), .zero_i(zero_i), .issue_valid_o(issue_valid_o),
  .issue_ready_i(issue_ready_i), .elem_o(elem_o), .sub_o(sub_o),
  .zero_wr_o(zero_wr_o), .commit_o(commit_o), .busy_o(busy_o),
  .done_o(done_o), .fault_o(fault_o), .illegal_o(illegal_o), .vl_o(vl_o)
);

// File: tb/tb_elem_loop_seq.sv
module tb_elem_loop_seq;
  localparam int MAXVL = 16;
  localparam int LW = $clog2(MAXVL + 1);
  localparam int EW = $clog2(MAXVL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [LW-1:0] vl_i = '0;
  logic [1:0] subvl_i = '0;
  logic [MAXVL-1:0] pred_i = '0;
  logic pred_x0_i = 1'b0, inv_i = 1'b0, zero_i = 1'b0, ffirst_i = 1'b0;
  logic [EW-1:0] resume_elem_i = '0;
  logic [1:0] resume_sub_i = '0;
  logic issue_ready_i = 1'b0, res_zero_i = 1'b0, res_fault_i = 1'b0;
  logic issue_valid_o, zero_wr_o, commit_o, busy_o, done_o, fault_o, illegal_o;
  logic [EW-1:0] elem_o;
  logic [1:0] sub_o;
  logic [LW-1:0] vl_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  elem_loop_seq #(.MAXVL(MAXVL)) dut (.*);

  // item encoding: {commit, zero_wr, elem[7:0], sub[1:0]}
  logic [11:0] act_q [0:127];
  logic [11:0] exp_q [0:127];
  int n_act, n_exp;
  int exp_vl;
  logic exp_done, exp_fault, exp_ill;
  int last_gap;

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic model(input int vl, input int sc, input logic [MAXVL-1:0] pred,
                       input bit x0, input bit inv, input bit zr, input bit ff,
                       input int fe, input int fs, input bit flt,
                       input int se, input int ss);
    logic [MAXVL-1:0] m;
    int veff, subn;
    bit stop;
    n_exp = 0; exp_fault = 0; exp_ill = 0; exp_done = 1; stop = 0;
    veff = (vl == 0) ? 1 : (vl > MAXVL ? MAXVL : vl);
    exp_vl = veff;
    subn = sc + 1;
    if (x0 && inv && zr) begin
      exp_ill = 1; exp_done = 0; return;
    end
    m = (x0 ? '0 : pred) ^ (inv ? {MAXVL{1'b1}} : '0);
    for (int e = se; e < veff && !stop; e++) begin
      if (!m[e] && !zr) continue;
      for (int s = (e == se ? ss : 0); s < subn && !stop; s++) begin
        if (ff && m[e] && e == fe && s == fs) begin
          exp_q[n_exp] = {1'b0, 1'b0, 8'(e), 2'(s)};
          n_exp++;
          stop = 1;
          if (flt && e == 0) begin exp_fault = 1; exp_done = 0; end
          else exp_vl = e;
        end else begin
          exp_q[n_exp] = {1'b1, ~m[e], 8'(e), 2'(s)};
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input int vl, input int sc,
                          input logic [MAXVL-1:0] pred, input bit x0, input bit inv,
                          input bit zr, input bit ff, input int fe, input int fs,
                          input bit flt, input bit stall, input int se, input int ss);
    bit got_done, got_fault, got_ill;
    int cyc, gap;
    model(vl, sc, pred, x0, inv, zr, ff, fe, fs, flt, se, ss);
    @(negedge clk);
    vl_i = LW'(vl); subvl_i = 2'(sc); pred_i = pred; pred_x0_i = x0; inv_i = inv;
    zero_i = zr; ffirst_i = ff; resume_elem_i = EW'(se); resume_sub_i = 2'(ss);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_act = 0; got_done = 0; got_fault = 0; got_ill = 0; cyc = 0; gap = 0;
    while (cyc < 2000) begin
      if (done_o || fault_o || illegal_o) begin
        got_done = done_o; got_fault = fault_o; got_ill = illegal_o;
        check(!busy_o, {tag, " R13 busy low at end"}, busy_o, 0);
        break;
      end
      issue_ready_i = stall ? ((cyc % 3) == 2) : 1'b1;
      res_zero_i  = issue_valid_o && elem_o == EW'(fe) && sub_o == 2'(fs) && !flt;
      res_fault_i = issue_valid_o && elem_o == EW'(fe) && sub_o == 2'(fs) && flt;
      #1;
      if (issue_valid_o && issue_ready_i) begin
        if (n_act < 128) act_q[n_act] = {commit_o, zero_wr_o, 8'(elem_o), sub_o};
        n_act++;
        gap = 0;
      end
      gap++;
      cyc++;
      @(negedge clk);
    end
    issue_ready_i = 1'b0; res_zero_i = 1'b0; res_fault_i = 1'b0;
    last_gap = gap;
    check(n_act == n_exp, {tag, " transfer count"}, n_act, n_exp);
    for (int i = 0; i < n_exp && i < n_act; i++)
      check(act_q[i] == exp_q[i], {tag, " transfer item"}, int'(act_q[i]), int'(exp_q[i]));
    check(got_done == exp_done, {tag, " done pulse"}, got_done, exp_done);
    check(got_fault == exp_fault, {tag, " R10 fault pulse"}, got_fault, exp_fault);
    check(got_ill == exp_ill, {tag, " R7 illegal pulse"}, got_ill, exp_ill);
    if (exp_done || exp_fault)
      check(int'(vl_o) == exp_vl, {tag, " vl_o"}, vl_o, exp_vl);
    @(negedge clk);
    check(!done_o && !fault_o && !illegal_o, {tag, " R13 single-cycle pulse"},
          int'({done_o, fault_o, illegal_o}), 0);
  endtask

  task automatic t_reset;
    check(!busy_o && !issue_valid_o && !done_o && !fault_o && !illegal_o,
          "R13 reset state", int'({busy_o, issue_valid_o, done_o}), 0);
  endtask

  task automatic t_basic;  // R2 order, R13 done timing
    run_case("R2 basic", 5, 1, '1, 0, 0, 0, 0, 99, 0, 0, 0, 0, 0);
    check(last_gap == 1, "R13 done one cycle after final transfer", last_gap, 1);
  endtask

  task automatic t_clamp;  // R1
    run_case("R1 zero req", 0, 0, '1, 0, 0, 0, 0, 99, 0, 0, 0, 0, 0);
    run_case("R1 over max", 20, 0, '1, 0, 0, 0, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_group;  // R3, R6 skip
    run_case("R3 group skip", 8, 2, 16'h00B2, 0, 0, 0, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_invert;  // R4
    run_case("R4 invert", 8, 1, 16'h00B2, 0, 1, 0, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_zeroing;  // R6
    run_case("R6 zeroing", 6, 1, 16'h0025, 0, 0, 1, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_x0;  // R5
    run_case("R5 x0 inverted", 6, 0, 16'h0005, 1, 1, 0, 0, 99, 0, 0, 0, 0, 0);
    run_case("R5 x0 plain", 6, 0, 16'hFFFF, 1, 0, 0, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reserved;  // R7
    run_case("R7 reserved", 6, 0, '1, 1, 1, 1, 0, 99, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stall;  // R8
    run_case("R8 stalled", 4, 3, 16'h000D, 0, 0, 0, 0, 99, 0, 0, 1, 0, 0);
  endtask

  task automatic t_ffirst;  // R9, R10
    run_case("R9 zero stop", 8, 1, '1, 0, 0, 0, 1, 3, 1, 0, 1, 0, 0);
    run_case("R9 zero at elem0", 8, 1, '1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    run_case("R10 fault at elem0", 8, 1, '1, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    run_case("R9 fault later", 8, 0, '1, 0, 0, 0, 1, 5, 0, 1, 0, 0, 0);
    run_case("R9 zero-write no stop", 6, 1, 16'h0033, 0, 0, 1, 1, 2, 0, 0, 1, 0, 0);
  endtask

  task automatic t_noff;  // R11
    run_case("R11 flags ignored", 6, 0, '1, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0);
    run_case("R11 fault ignored", 6, 0, '1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_resume;  // R12
    run_case("R12 resume", 6, 2, '1, 0, 0, 0, 0, 99, 0, 0, 0, 2, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clamp();
    t_group();
    t_invert();
    t_zeroing();
    t_x0();
    t_reserved();
    t_stall();
    t_ffirst();
    t_noff();
    t_resume();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule